// File: doc/BRIEF.md
# Hamming Page Chunk ECC Engine

The engine protects NAND page data with a Hamming code that corrects one bit and detects two bits. It works on 512-byte chunks, and a page holds one, two or four of them. The page arrives as a byte stream, one byte per cycle in which `in_valid` is high. Each chunk gets a 6-byte digest. All digests sit together at the start of the spare area, in chunk order. Any free spare bytes follow them and are outside this block's stream.

A write page (`mode` = 0) takes the page data. From the cycle after the last data byte, the block then drives the digests out on `dig_data`, one byte per cycle. A read page (`mode` = 1) takes the page data and then the stored digests. After each chunk's sixth digest byte, the block reports a one-cycle status for that chunk. The status gives one of four results: clean, a corrected data bit (with its location), a corrected digest bit, or uncorrectable.

Top module: `hamming_page_ecc`

## Requirements
- R1: A `start` pulse while idle opens a page. On that pulse the block samples `mode` and `chunks_cfg` and holds them until the page ends. The page has 1 chunk when `chunks_cfg` is 0, 2 chunks when it is 1, and 4 chunks when it is 2 or 3.
- R2: In a chunk, data bit b of byte n has address a = 8*n + b (12 bits). Parity bit p[2k+a[k]] is the XOR of every data bit whose address has bit k equal to a[k], for k = 0 to 11. Digest byte j (j = 0, 1, 2) equals the bitwise inverse of p[8j+7:8j]. Digest bytes 3, 4 and 5 are always 0xFF.
- R3: In write mode, `dig_valid` goes high in the cycle after the page's last data byte is accepted. It stays high for 6 times the chunk count consecutive cycles. During those cycles `dig_data` presents the digests in chunk order, bytes 0 to 5 of each chunk.
- R4: In read mode, a chunk whose data and digest are intact reports `st_kind` = 0. The encoding is: 0 clean, 1 corrected data bit, 2 corrected digest bit, 3 uncorrectable.
- R5: One flipped data bit in a chunk reports `st_kind` = 1, with `st_offset` set to the byte offset in the chunk and `st_bit` set to the bit index.
- R6: One flipped bit in a stored digest (parity or padding byte), with the data intact, reports `st_kind` = 2 with `st_offset` = 0 and `st_bit` = 0.
- R7: Any two flipped bits in a chunk (data, digest or one of each) report `st_kind` = 3.
- R8: An erased page, in which every data and digest byte is 0xFF, reports `st_kind` = 0 for every chunk. A write of all-0xFF data yields all-0xFF digests.
- R9: `st_valid` is a one-cycle pulse in the cycle after a chunk's sixth digest byte is accepted. `st_chunk` gives the index of that chunk, counting from 0.
- R10: Cycles with `in_valid` low consume no byte and do not disturb the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a page when idle |
| mode | input | 1 | 0 write (encode), 1 read (check); sampled on start |
| chunks_cfg | input | 2 | Chunk count select; sampled on start |
| in_valid | input | 1 | A byte is present on in_data |
| in_data | input | 8 | Page data, then (read) stored digests |
| dig_valid | output | 1 | A digest byte is on dig_data (write) |
| dig_data | output | 8 | Digest byte |
| st_valid | output | 1 | Chunk status pulse (read) |
| st_chunk | output | 2 | Chunk index of the status |
| st_kind | output | 2 | Status code |
| st_offset | output | 9 | Byte offset of a corrected data bit |
| st_bit | output | 3 | Bit index of a corrected data bit |

## Verification
On every cycle, the checker confirms the timing relations. A status pulse always follows an accepted byte and lasts exactly one cycle, and the chunk it names lies within the page. Digest output begins only right after an accepted data byte and never overlaps a status pulse. The checker also confirms that a corrected digest bit carries no location. The digest values, the located bit positions, the detection of double flips, the handling of erased pages and the effect of input gaps depend on the data contents. Only the bench scenarios show them, by comparing against an independent parity model.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_SPARE = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ST_CLEAN      = 2'd0,
    ST_FIX_DATA   = 2'd1,
    ST_FIX_DIGEST = 2'd2,
    ST_UNCORR     = 2'd3
  } ecc_kind_t;
endpackage

// File: rtl/hpe_parity_acc.sv
// Per-byte update of the paired line/column parity over one chunk.
module hpe_parity_acc #(
  parameter int OFF_W = 9,
  parameter int PAR_W = 2 * (OFF_W + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [OFF_W-1:0] offset,
  input  logic [7:0]       in_byte,
  output logic [PAR_W-1:0] par_upd
);
  logic [PAR_W-1:0] par_q;
  logic [PAR_W-1:0] par_d;
  logic             byte_par;

  always_comb begin
    par_upd  = par_q;
    byte_par = ^in_byte;
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 3; k++) begin
        par_upd[2*k + ((b >> k) & 1)] ^= in_byte[b];
      end
    end
    for (int k = 0; k < OFF_W; k++) begin
      par_upd[2*(k+3) + int'(offset[k])] ^= byte_par;
    end
  end

  always_comb begin
    par_d = par_q;
    if (clr)     par_d = '0;
    else if (en) par_d = par_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else        par_q <= par_d;
  end
endmodule

// File: rtl/hpe_syndrome_dec.sv
// Classifies a chunk syndrome into clean / data fix / digest fix / uncorrectable.
module hpe_syndrome_dec
  import hpe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAD_W  = 24
) (
  input  logic [2*ADDR_W-1:0] syn_par,
  input  logic [PAD_W-1:0]    syn_pad,
  output ecc_kind_t           kind,
  output logic [ADDR_W-1:0]   loc
);
  logic              pairs_split;
  logic [ADDR_W-1:0] loc_raw;
  int                nbits;

  always_comb begin
    pairs_split = 1'b1;
    for (int k = 0; k < ADDR_W; k++) begin
      pairs_split &= syn_par[2*k] ^ syn_par[2*k+1];
      loc_raw[k]   = syn_par[2*k+1];
    end
    nbits = $countones(syn_par) + $countones(syn_pad);
    loc   = '0;
    if (nbits == 0) begin
      kind = ST_CLEAN;
    end else if (pairs_split && (syn_pad == '0)) begin
      kind = ST_FIX_DATA;
      loc  = loc_raw;
    end else if (nbits == 1) begin
      kind = ST_FIX_DIGEST;
    end else begin
      kind = ST_UNCORR;
    end
  end
endmodule

// File: rtl/hamming_page_ecc.sv
module hamming_page_ecc
  import hpe_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int MAX_CHUNKS  = 4,
  parameter int DIG_BYTES   = 6,
  parameter int OFF_W       = $clog2(CHUNK_BYTES),
  parameter int CH_W        = $clog2(MAX_CHUNKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [1:0]       chunks_cfg,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             dig_valid,
  output logic [7:0]       dig_data,
  output logic             st_valid,
  output logic [CH_W-1:0]  st_chunk,
  output logic [1:0]       st_kind,
  output logic [OFF_W-1:0] st_offset,
  output logic [2:0]       st_bit
);
  localparam int ADDR_W    = OFF_W + 3;
  localparam int PAR_W     = 2 * ADDR_W;
  localparam int PAR_BYTES = PAR_W / 8;
  localparam int SYN_W     = 8 * DIG_BYTES;
  localparam int PAD_W     = SYN_W - PAR_W;
  localparam int DB_W      = $clog2(DIG_BYTES);

  phase_t           phase_q, phase_d;
  logic             mode_q, mode_d;
  logic [CH_W-1:0]  last_chunk_q, last_chunk_d, cfg_last;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CH_W-1:0]  chunk_q, chunk_d;
  logic [DB_W-1:0]  dbyte_q, dbyte_d;
  logic [SYN_W-1:0] syn_q, syn_d, syn_full;
  logic [PAR_W-1:0] par_mem [MAX_CHUNKS];
  logic [PAR_W-1:0] par_upd, cur_par, par_shift;
  logic             acc_en, acc_clr, chunk_end, spare_adv, spare_last, st_load;
  logic [7:0]       exp_byte, syn_byte;
  ecc_kind_t        dec_kind;
  logic [ADDR_W-1:0] dec_loc;

  always_comb begin
    int n;
    n = 1 << chunks_cfg;
    if (n > MAX_CHUNKS) n = MAX_CHUNKS;
    cfg_last = CH_W'(n - 1);
  end

  assign acc_en    = (phase_q == PH_DATA) && in_valid;
  assign chunk_end = acc_en && (off_q == OFF_W'(CHUNK_BYTES - 1));
  assign acc_clr   = ((phase_q == PH_IDLE) && start) || chunk_end;

  hpe_parity_acc #(.OFF_W(OFF_W), .PAR_W(PAR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .clr(acc_clr),
    .offset(off_q), .in_byte(in_data), .par_upd(par_upd)
  );

  // Expected digest byte for the current chunk; parity stored inverted, padding 0xFF.
  assign cur_par   = par_mem[chunk_q];
  assign par_shift = cur_par >> {dbyte_q, 3'b000};
  assign exp_byte  = (int'(dbyte_q) < PAR_BYTES) ? ~par_shift[7:0] : 8'hFF;
  assign syn_byte  = exp_byte ^ in_data;
  assign syn_full  = syn_q | ({{(SYN_W-8){1'b0}}, syn_byte} << {dbyte_q, 3'b000});

  hpe_syndrome_dec #(.ADDR_W(ADDR_W), .PAD_W(PAD_W)) u_dec (
    .syn_par(syn_full[PAR_W-1:0]), .syn_pad(syn_full[SYN_W-1:PAR_W]),
    .kind(dec_kind), .loc(dec_loc)
  );

  assign spare_adv  = (phase_q == PH_SPARE) && (mode_q ? in_valid : 1'b1);
  assign spare_last = spare_adv && (dbyte_q == DB_W'(DIG_BYTES - 1));
  assign st_load    = spare_last && mode_q;

  always_comb begin
    phase_d      = phase_q;
    mode_d       = mode_q;
    last_chunk_d = last_chunk_q;
    off_d        = off_q;
    chunk_d      = chunk_q;
    dbyte_d      = dbyte_q;
    syn_d        = syn_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d      = PH_DATA;
        mode_d       = mode;
        last_chunk_d = cfg_last;
        off_d        = '0;
        chunk_d      = '0;
      end
      PH_DATA: if (acc_en) begin
        off_d = off_q + 1'b1;
        if (chunk_end) begin
          chunk_d = chunk_q + 1'b1;
          if (chunk_q == last_chunk_q) begin
            phase_d = PH_SPARE;
            chunk_d = '0;
            dbyte_d = '0;
            syn_d   = '0;
          end
        end
      end
      PH_SPARE: if (spare_adv) begin
        dbyte_d = dbyte_q + 1'b1;
        syn_d   = syn_full;
        if (spare_last) begin
          dbyte_d = '0;
          syn_d   = '0;
          chunk_d = chunk_q + 1'b1;
          if (chunk_q == last_chunk_q) phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      mode_q       <= 1'b0;
      last_chunk_q <= '0;
      off_q        <= '0;
      chunk_q      <= '0;
      dbyte_q      <= '0;
      syn_q        <= '0;
    end else begin
      phase_q      <= phase_d;
      mode_q       <= mode_d;
      last_chunk_q <= last_chunk_d;
      off_q        <= off_d;
      chunk_q      <= chunk_d;
      dbyte_q      <= dbyte_d;
      syn_q        <= syn_d;
    end
  end

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_par_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    par_mem[c] <= '0;
      else if (chunk_end && (chunk_q == CH_W'(c)))   par_mem[c] <= par_upd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid  <= 1'b0;
      st_chunk  <= '0;
      st_kind   <= 2'd0;
      st_offset <= '0;
      st_bit    <= '0;
    end else begin
      st_valid <= st_load;
      if (st_load) begin
        st_chunk  <= chunk_q;
        st_kind   <= dec_kind;
        st_offset <= dec_loc[ADDR_W-1:3];
        st_bit    <= dec_loc[2:0];
      end
    end
  end

  assign dig_valid = (phase_q == PH_SPARE) && !mode_q;
  assign dig_data  = exp_byte;
endmodule

// File: rtl/hpe_checker.sv
module hpe_checker #(
  parameter int CH_W  = 2,
  parameter int OFF_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             dig_valid,
  input logic             st_valid,
  input logic [CH_W-1:0]  st_chunk,
  input logic [1:0]       st_kind,
  input logic [OFF_W-1:0] st_offset,
  input logic [2:0]       st_bit,
  input logic [CH_W-1:0]  last_chunk_q
);
  assert_status_follows_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid));

  assert_status_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  assert_digest_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dig_valid) |-> $past(in_valid));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dig_valid && st_valid));

  assert_digest_fix_no_loc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_kind == 2'd2) |-> (st_offset == '0 && st_bit == 3'd0));

  assert_chunk_in_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_chunk <= last_chunk_q));
endmodule

bind hamming_page_ecc hpe_checker #(.CH_W(CH_W), .OFF_W(OFF_W)) u_hpe_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dig_valid(dig_valid),
  .st_valid(st_valid), .st_chunk(st_chunk), .st_kind(st_kind),
  .st_offset(st_offset), .st_bit(st_bit), .last_chunk_q(last_chunk_q)
);

// File: tb/hamming_page_ecc_bench.sv
module hamming_page_ecc_bench;
  logic       clk, rst_n, start, mode, in_valid;
  logic [1:0] chunks_cfg;
  logic [7:0] in_data;
  logic       dig_valid, st_valid;
  logic [7:0] dig_data;
  logic [1:0] st_chunk, st_kind;
  logic [8:0] st_offset;
  logic [2:0] st_bit;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] page [0:2047];
  logic [7:0] edig [0:23];
  int exp_kind [4];
  int exp_off  [4];
  int exp_bit  [4];

  hamming_page_ecc u_hamming_page_ecc (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chunks_cfg(chunks_cfg),
    .in_valid(in_valid), .in_data(in_data), .dig_valid(dig_valid), .dig_data(dig_data),
    .st_valid(st_valid), .st_chunk(st_chunk), .st_kind(st_kind),
    .st_offset(st_offset), .st_bit(st_bit)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent parity model: per bit address, XOR into the slot chosen by each address bit.
  task automatic make_digests(input int n);
    for (int c = 0; c < n; c++) begin
      logic [23:0] p;
      p = '0;
      for (int i = 0; i < 512; i++) begin
        for (int b = 0; b < 8; b++) begin
          if (page[c*512 + i][b]) begin
            int a;
            a = i * 8 + b;
            for (int k = 0; k < 12; k++) p[2*k + ((a >> k) & 1)] = ~p[2*k + ((a >> k) & 1)];
          end
        end
      end
      for (int j = 0; j < 6; j++) edig[c*6 + j] = (j < 3) ? ~p[8*j +: 8] : 8'hFF;
    end
  endtask

  task automatic fill(input int seed, input bit erased);
    for (int i = 0; i < 2048; i++) page[i] = erased ? 8'hFF : 8'(i * 37 + (i >> 5) * seed + seed);
  endtask

  task automatic open_page(input logic m, input logic [1:0] cfg);
    @(negedge clk);
    start = 1; mode = m; chunks_cfg = cfg;
    @(negedge clk);
    start = 0; mode = ~m; chunks_cfg = 2'd0;   // changes after start must not matter
  endtask

  // R10: inserts idle cycles in the stream
  task automatic send_data(input int n);
    for (int i = 0; i < n * 512; i++) begin
      if (i % 211 == 100) begin
        @(negedge clk); in_valid = 0; in_data = 8'h5A;
      end
      @(negedge clk); in_valid = 1; in_data = page[i];
    end
  endtask

  task automatic run_write(input logic [1:0] cfg, input int n, input string tag);
    open_page(1'b0, cfg);
    send_data(n);
    for (int k = 0; k < n * 6; k++) begin
      @(negedge clk); in_valid = 0;
      chk(dig_valid === 1'b1, {tag, " R3 dig_valid"}, int'(dig_valid), 1);
      chk(dig_data === edig[k], {tag, " R2 digest byte"}, int'(dig_data), int'(edig[k]));
    end
    @(negedge clk);
    chk(dig_valid === 1'b0, {tag, " R3 digest end"}, int'(dig_valid), 0);
  endtask

  task automatic run_read(input logic [1:0] cfg, input int n, input string tag);
    open_page(1'b1, cfg);
    send_data(n);
    for (int c = 0; c < n; c++) begin
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        if (j == 5) chk(st_valid === 1'b0, {tag, " R9 no early status"}, int'(st_valid), 0);
        in_valid = 1; in_data = edig[c*6 + j];
      end
      @(negedge clk); in_valid = 0;
      chk(st_valid === 1'b1, {tag, " R9 status pulse"}, int'(st_valid), 1);
      chk(int'(st_chunk) == c, {tag, " R9 chunk index"}, int'(st_chunk), c);
      chk(int'(st_kind) == exp_kind[c], {tag, " kind"}, int'(st_kind), exp_kind[c]);
      chk(int'(st_offset) == exp_off[c], {tag, " offset"}, int'(st_offset), exp_off[c]);
      chk(int'(st_bit) == exp_bit[c], {tag, " bit"}, int'(st_bit), exp_bit[c]);
    end
    @(negedge clk);
    chk(st_valid === 1'b0, {tag, " R9 pulse ends"}, int'(st_valid), 0);
  endtask

  task automatic clear_exp();
    for (int c = 0; c < 4; c++) begin exp_kind[c] = 0; exp_off[c] = 0; exp_bit[c] = 0; end
  endtask

  task automatic t_reset();
    chk(dig_valid === 1'b0, "reset dig_valid", int'(dig_valid), 0);
    chk(st_valid === 1'b0, "reset st_valid", int'(st_valid), 0);
  endtask

  task automatic t_write_single();  fill(3, 0); make_digests(1); run_write(2'd0, 1, "R1 one chunk");  endtask
  task automatic t_write_four();    fill(11, 0); make_digests(4); run_write(2'd2, 4, "R3 four chunks"); endtask
  task automatic t_write_cfg3();    fill(5, 0); make_digests(4); run_write(2'd3, 4, "R1 cfg3"); endtask
  task automatic t_write_erased();
    fill(0, 1); make_digests(2);
    for (int k = 0; k < 12; k++) chk(edig[k] == 8'hFF, "R8 model erased digest", int'(edig[k]), 255);
    run_write(2'd1, 2, "R8 erased write");
  endtask
  task automatic t_read_clean();    fill(7, 0); make_digests(2); clear_exp(); run_read(2'd1, 2, "R4 clean"); endtask
  task automatic t_read_data_fix();
    fill(9, 0); make_digests(4); clear_exp();
    page[512 + 300][5] = ~page[512 + 300][5];
    exp_kind[1] = 1; exp_off[1] = 300; exp_bit[1] = 5;
    page[3*512 + 511][0] = ~page[3*512 + 511][0];
    exp_kind[3] = 1; exp_off[3] = 511; exp_bit[3] = 0;
    run_read(2'd2, 4, "R5 data fix");
  endtask
  task automatic t_read_digest_fix();
    fill(13, 0); make_digests(2); clear_exp();
    edig[1][3] = ~edig[1][3];  exp_kind[0] = 2;
    edig[6+4][7] = ~edig[6+4][7]; exp_kind[1] = 2;
    run_read(2'd1, 2, "R6 digest fix");
  endtask
  task automatic t_read_double();
    fill(17, 0); make_digests(2); clear_exp();
    page[10][1] = ~page[10][1]; page[400][6] = ~page[400][6]; exp_kind[0] = 3;
    page[512 + 77][2] = ~page[512 + 77][2]; edig[6+0][0] = ~edig[6+0][0]; exp_kind[1] = 3;
    run_read(2'd1, 2, "R7 double");
  endtask
  task automatic t_read_erased();
    fill(0, 1); for (int k = 0; k < 24; k++) edig[k] = 8'hFF; clear_exp();
    run_read(2'd2, 4, "R8 erased read");
  endtask

  initial begin
    rst_n = 0; start = 0; mode = 0; chunks_cfg = 0; in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_single();
    t_write_four();
    t_write_cfg3();
    t_write_erased();
    t_read_clean();
    t_read_data_fix();
    t_read_digest_fix();
    t_read_double();
    t_read_erased();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule